// File: doc/BRIEF.md
# Grouped pin pattern interrupt

This block watches a bank of digital input pins and raises a single interrupt when a programmed pattern appears on them. Software picks which pins take part and which level counts as active on each pin. The active, enabled pins are then reduced to one group condition by either an OR or an AND. The group condition either latches on its false-to-true transition (edge mode) or sets the pending bit in every cycle it is true (level mode). A write-one-to-clear bit in the control register removes a pending interrupt.

The pins pass through a two-flop synchronizer before the trigger logic. A second copy of the reduction runs on the raw pins and drives a wake request with no clock in its path, so a power controller can restart the clocks before the synchronized interrupt is raised. A pin whose pad is switched to an analog function is expected to arrive as logic 0. Pin muxing, clock gating and the power controller sit outside the block.

Top module: `pin_group_irq`

## Requirements
- R1: After reset, irq and wake are 0 and all three registers read 0.
- R2: The register at address 1 (active-level select, bit i for pin i) and the register at address 2 (pin enable, bit i for pin i) read back what was written. Address 3 reads 0. Read data is registered and appears one clock after the address is presented.
- R3: A pin whose enable bit is 0 has no effect on wake or irq.
- R4: An active-level bit of 1 makes a high pin active, and a bit of 0 makes a low pin active.
- R5: With control bit 1 at 0, the group condition is true when any enabled pin is active.
- R6: With control bit 1 at 1, the group condition is true only when every enabled pin is active. With no pin enabled the condition is false in both combine modes.
- R7: With control bit 2 at 0 (edge mode), the pending bit sets on a false-to-true transition of the synchronized condition, with irq rising on the third rising clock edge after the pins change, and stays set after the condition returns to false.
- R8: Writing the control register (address 0) with bit 0 at 1 clears the pending bit at that clock edge. A write with bit 0 at 0 leaves it set. In edge mode a clear that meets a new edge in the same cycle leaves the bit set.
- R9: With control bit 2 at 1 (level mode), the pending bit sets on every clock edge at which the synchronized condition is true and no clear is written. After a clear with the condition still true it sets again one clock later.
- R10: wake is a combinational function of the unsynchronized pins, the enable and active-level registers and the combine mode, and follows a pin change with no clock edge.
- R11: irq equals bit 0 of the control register as read back, and bits 1 and 2 read back the combine and trigger modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | NUM_PINS | Raw pin levels, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 active level, 2 enable |
| wdata | input | NUM_PINS | Register write data |
| rdata | output | NUM_PINS | Registered read data for the previous cycle's address |
| irq | output | 1 | Pending interrupt, registered |
| wake | output | 1 | Unclocked wake request from the raw pin condition |

## Verification
A wrong pending bit shows on irq at the very next clock edge and on bit 0 of the control read one clock after that; a lost edge detector state shows as a missing or repeated interrupt three edges after a pin change. A wrong reduction or active-level mapping shows immediately on wake, with no clock, so the bench sweeps every enable, level and pin pattern of a four-pin instance in both combine modes against an arithmetic model. Timing of irq is checked at the exact edge, one edge early and during coincident clears.

// File: rtl/pgi_pkg.sv
package pgi_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd2;

  localparam int CTRL_PEND_BIT = 0;
  localparam int CTRL_AND_BIT  = 1;
  localparam int CTRL_TRIG_BIT = 2;
  localparam int CTRL_BITS     = 3;

  typedef struct packed {
    logic level_trig;
    logic and_mode;
  } pgi_mode_t;
endpackage

// File: rtl/pgi_sync.sv
module pgi_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pgi_combine.sv
module pgi_combine #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] in,
  input  logic [WIDTH-1:0] level_hi,
  input  logic [WIDTH-1:0] enable,
  input  logic             and_mode,
  output logic             cond
);
  logic [WIDTH-1:0] active;
  logic             any_on;
  logic             all_on;

  always_comb begin
    active = ~(in ^ level_hi) & enable;
    any_on = |active;
    all_on = &(active | ~enable);
    cond   = (|enable) & (and_mode ? all_on : any_on);
  end
endmodule

// File: rtl/pgi_regs.sv
module pgi_regs
  import pgi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              pending,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  level_hi,
  output logic [WIDTH-1:0]  enable,
  output pgi_mode_t         mode,
  output logic              clr
);
  localparam int PAD = WIDTH - CTRL_BITS;

  logic [WIDTH-1:0] ctrl_view;

  assign clr = wr_en && (addr == ADDR_CTRL) && wdata[CTRL_PEND_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      level_hi <= '0;
      enable   <= '0;
      mode     <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_CTRL: begin
          mode.and_mode   <= wdata[CTRL_AND_BIT];
          mode.level_trig <= wdata[CTRL_TRIG_BIT];
        end
        ADDR_LEVEL: level_hi <= wdata;
        ADDR_EN:    enable   <= wdata;
        default: ;
      endcase
    end
  end

  assign ctrl_view = {{PAD{1'b0}}, mode.level_trig, mode.and_mode, pending};

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        ADDR_CTRL:  rdata <= ctrl_view;
        ADDR_LEVEL: rdata <= level_hi;
        ADDR_EN:    rdata <= enable;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pgi_trigger.sv
module pgi_trigger (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic level_trig,
  input  logic clr,
  output logic pending,
  output logic cond_q
);
  logic rise;

  assign rise = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cond_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      if (level_trig)
        pending <= ~clr & (pending | cond);
      else
        pending <= rise | (pending & ~clr);
    end
  end
endmodule

// File: rtl/pin_group_irq.sv
module pin_group_irq
  import pgi_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] rdata,
  output logic                irq,
  output logic                wake
);
  logic [NUM_PINS-1:0] level_hi;
  logic [NUM_PINS-1:0] enable;
  logic [NUM_PINS-1:0] pins_s;
  pgi_mode_t           mode;
  logic                clr;
  logic                pending;
  logic                sync_cond;
  logic                cond_q;

  pgi_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pending(pending), .rdata(rdata), .level_hi(level_hi),
    .enable(enable), .mode(mode), .clr(clr)
  );

  pgi_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins), .q(pins_s)
  );

  pgi_combine #(.WIDTH(NUM_PINS)) u_comb_sync (
    .in(pins_s), .level_hi(level_hi), .enable(enable),
    .and_mode(mode.and_mode), .cond(sync_cond)
  );

  pgi_combine #(.WIDTH(NUM_PINS)) u_comb_raw (
    .in(pins), .level_hi(level_hi), .enable(enable),
    .and_mode(mode.and_mode), .cond(wake)
  );

  pgi_trigger u_trig (
    .clk(clk), .rst(rst), .cond(sync_cond), .level_trig(mode.level_trig),
    .clr(clr), .pending(pending), .cond_q(cond_q)
  );

  assign irq = pending;
endmodule

// File: rtl/pgi_checker.sv
module pgi_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic         wbit0,
  input logic         level_trig,
  input logic         cond,
  input logic         cond_q,
  input logic [N-1:0] enable,
  input logic         irq,
  input logic         wake
);
  logic clr_wr;
  assign clr_wr = wr_en && (addr == 2'd0) && wbit0;

  a_r8_clear_drops_edge: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !level_trig && !(cond && !cond_q)) |=> !irq);

  a_r7_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr) |=> irq);

  a_r7_rise_needs_cond: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cond));

  a_r9_level_sets: assert property (@(posedge clk) disable iff (rst)
    (level_trig && cond && !clr_wr) |=> irq);

  a_r9_level_clear: assert property (@(posedge clk) disable iff (rst)
    (level_trig && clr_wr) |=> !irq);

  a_r6_empty_no_wake: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |-> !wake);
endmodule

bind pin_group_irq pgi_checker #(.N(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
  .level_trig(mode.level_trig), .cond(sync_cond), .cond_q(cond_q),
  .enable(enable), .irq(irq), .wake(wake)
);

// File: tb/pin_group_irq_test.sv
module pin_group_irq_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;
  logic         wake;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  pin_group_irq #(.NUM_PINS(N)) uut (
    .clk(clk), .rst(rst), .pins(pins), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
  );

  function automatic logic model(logic [N-1:0] en, logic [N-1:0] lv,
                                 logic [N-1:0] p, logic andm);
    logic [N-1:0] act;
    act = ~(p ^ lv) & en;
    if (en == '0) return 1'b0;
    return andm ? (act == en) : (act != '0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 level", d, 0);
    rd(2'd2, d); check("R1 enable", d, 0);

    // R2 readback
    wr(2'd1, 4'hA); rd(2'd1, d); check("R2 level readback", d, 4'hA);
    wr(2'd2, 4'h5); rd(2'd2, d); check("R2 enable readback", d, 4'h5);
    rd(2'd3, d); check("R2 unused address", d, 0);

    // R3 R4 R5 R6 R10: exhaustive wake sweep, no clock between pin change and check
    for (int en = 0; en < 16; en++) begin
      wr(2'd2, en[N-1:0]);
      for (int lv = 0; lv < 16; lv++) begin
        wr(2'd1, lv[N-1:0]);
        for (int m = 0; m < 2; m++) begin
          wr(2'd0, {1'b0, m[0], 1'b1});
          for (int p = 0; p < 16; p++) begin
            pins = p[N-1:0];
            #1;
            check("R10 R3 R4 R5 R6 wake", wake,
                  model(en[N-1:0], lv[N-1:0], p[N-1:0], m[0]));
          end
          pins = '0;
          @(negedge clk);
        end
      end
    end

    // R7 R8 edge mode, OR: pins 0,1 enabled, active high
    wr(2'd2, 4'b0011);
    wr(2'd1, 4'b0011);
    pins = '0;
    wait_n(4);
    wr(2'd0, 3'b001);
    check("R8 clear", irq, 0);
    pins = 4'b0100;
    wait_n(4);
    check("R3 disabled pin no irq", irq, 0);
    pins = 4'b0001;
    wait_n(2);
    check("R7 not yet after two edges", irq, 0);
    wait_n(1);
    check("R7 set on third edge", irq, 1);
    pins = '0;
    wait_n(4);
    check("R7 holds after condition falls", irq, 1);
    wr(2'd0, 3'b000);
    check("R8 zero write keeps pending", irq, 1);
    rd(2'd0, d);
    check("R11 ctrl reads pending and modes", d, 4'b0001);
    wr(2'd0, 3'b001);
    check("R8 clear in edge mode", irq, 0);
    wait_n(3);
    check("R7 no re-set without new edge", irq, 0);
    pins = 4'b0001;
    wait_n(2);
    wr(2'd0, 3'b001);
    check("R8 clear with coincident edge keeps set", irq, 1);
    pins = '0;
    wait_n(3);
    wr(2'd0, 3'b001);

    // R9 level mode
    wr(2'd0, 3'b101);
    pins = 4'b0010;
    wait_n(3);
    check("R9 level sets", irq, 1);
    rd(2'd0, d);
    check("R11 ctrl level mode", d, 4'b0101);
    wr(2'd0, 3'b101);
    check("R9 clear drops", irq, 0);
    wait_n(1);
    check("R9 re-sets next cycle", irq, 1);
    pins = '0;
    wait_n(3);
    wr(2'd0, 3'b101);
    check("R9 cleared with condition false", irq, 0);
    wait_n(2);
    check("R9 stays clear", irq, 0);

    // R6 AND mode edge: pin0 active high, pin1 active low
    wr(2'd1, 4'b0001);
    wr(2'd0, 3'b011);
    pins = 4'b0011;
    wait_n(4);
    wr(2'd0, 3'b011);
    wait_n(3);
    check("R6 AND partial no irq", irq, 0);
    pins = 4'b1001;
    wait_n(3);
    check("R6 AND all active irq", irq, 1);

    // R6 empty group in AND level mode
    wr(2'd2, 4'b0000);
    wr(2'd0, 3'b111);
    for (int p = 0; p < 16; p++) begin
      pins = p[N-1:0];
      wait_n(3);
      check("R6 empty AND group quiet", irq, 0);
    end

    // R9 R5 R6 level-mode irq sweep against the model
    for (int c = 0; c < 8; c++) begin
      logic [N-1:0] en_v, lv_v;
      logic andm;
      en_v = c[0] ? 4'b1111 : 4'b0101;
      lv_v = c[1] ? 4'b1100 : 4'b0011;
      andm = c[2];
      wr(2'd2, en_v);
      wr(2'd1, lv_v);
      for (int p = 0; p < 16; p++) begin
        pins = p[N-1:0];
        wait_n(3);
        wr(2'd0, {1'b1, andm, 1'b1});
        wait_n(1);
        check("R9 level irq follows condition", irq,
              model(en_v, lv_v, p[N-1:0], andm));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule